// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt control path of a small 8-bit processor core. It holds the program counter, the stack pointer and the global interrupt enable flag. When the decoder reports a software-interrupt opcode, or when a hardware request is pending while the enable flag is set, the block saves the program counter on the stack as two bytes. It then moves the stack pointer down by two and sends fetch to one fixed vector. The whole entry takes a fixed number of cycles.

Three return strobes undo the entry. Each one pops two bytes, restores the program counter and moves the stack pointer up by two. The first variant is a plain return. The second also skips one address, so that a software interrupt does not run again. The third also sets the enable flag again.

Reads of memory that does not exist return fixed values. Program memory beyond the implemented size reads as 0x00, which is the software-interrupt opcode. Stack memory above the implemented top reads as 0xFF. Because of this, code that runs away, or a return with nothing on the stack, ends up in a trap. The stack memory is outside the block and has an asynchronous read port. The block drives its address, its write data and its write enable.

Top module: `irq_seq`

## Requirements
- R1: After reset, the program counter is 0, the stack pointer is RAM_TOP (default 0x6F), the enable flag is 0 and busy is 0.
- R2: While idle, a software-interrupt strobe, or a hardware request with the enable flag set, starts an entry. Busy stays high for exactly ENTRY_CYC cycles (default 7) after the accepting edge. Afterwards the program counter holds VECTOR (default 0x00FF).
- R3: An entry writes exactly two stack bytes, and only while busy. The PC low byte goes to the address in SP. The PC high bits, zero-extended to a byte, go to SP-1. When the entry ends, SP has dropped by 2.
- R4: A hardware entry clears the enable flag. A software entry leaves the flag unchanged.
- R5: A hardware request while the enable flag is 0 is ignored: busy stays low and the PC does not change.
- R6: Plain return, return-and-skip and return-from-interrupt each keep busy high for 2 cycles. Each reads the high bits from SP+1 and the low byte from SP+2, and raises SP by 2. Only return-from-interrupt sets the enable flag.
- R7: Return-and-skip loads the restored address plus one.
- R8: A stack read at an address above RAM_TOP returns 0xFF. A return on an empty stack therefore loads an all-ones PC.
- R9: The program-byte output equals the memory data when PC < ROM_WORDS (default 2048), and 0x00 otherwise.
- R10: A hardware request is still taken when the enable flag is cleared by software in the accepting cycle.
- R11: Set and clear requests for the enable flag act only while idle, with clear winning. Setting the flag inside a handler allows a nested hardware entry.
- R12: While busy, every strobe and the PC-increment request are ignored. While idle with no other strobe, the increment request adds one to the PC.
- R13: A software strobe and an enabled hardware request in the same cycle: the software entry is taken and the enable flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_irq_i | input | 1 | Pending hardware interrupt request (level) |
| swi_i | input | 1 | Software-interrupt opcode strobe |
| ret_i | input | 1 | Plain return strobe |
| retsk_i | input | 1 | Return-and-skip strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| gie_set_i | input | 1 | Software request to set the enable flag |
| gie_clr_i | input | 1 | Software request to clear the enable flag |
| pc_inc_i | input | 1 | Advance the PC by one |
| rom_addr_o | output | PC_W | Program memory address (equals PC) |
| rom_rdata_i | input | 8 | Raw program memory data |
| rom_data_o | output | 8 | Program byte after the unimplemented-area mapping |
| mem_we_o | output | 1 | Stack memory write enable |
| mem_addr_o | output | SP_W | Stack memory address |
| mem_wdata_o | output | 8 | Stack memory write data |
| mem_rdata_i | input | 8 | Stack memory read data (asynchronous) |
| pc_o | output | PC_W | Program counter |
| sp_o | output | SP_W | Stack pointer |
| gie_o | output | 1 | Global interrupt enable flag |
| busy_o | output | 1 | Entry or return sequence in progress |

## Verification
The hardest case to reach from the ports is a return whose pops read above the implemented stack top. It only happens after more returns than entries, which balanced random traffic never produces. The bench resets the block and issues a return on the empty stack. It then checks the all-ones PC and the zero program byte that follows.

The same-cycle races also need directed stimulus. These are the enable clear together with a hardware request, the software strobe together with a hardware request, and strobes sent in the middle of an entry. Around these directed cases, seeded random sequences of entries, nested entries and all three return flavours are checked against a bench model of the stack.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ENTRY  = 2'd1,
        ST_RETURN = 2'd2
    } seq_st_e;

    typedef enum logic [1:0] {
        RK_PLAIN = 2'd0,
        RK_SKIP  = 2'd1,
        RK_IRQ   = 2'd2
    } ret_kind_e;

endpackage

// File: rtl/irq_mem_guard.sv
// Substitutes a fixed byte for reads at or beyond the first unimplemented address.
module irq_mem_guard #(
    parameter int unsigned AW    = 8,
    parameter int unsigned LIMIT = 112,
    parameter logic [7:0]  FILL  = 8'hFF
) (
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    data_i,
    output logic [7:0]    data_o
);
    localparam logic [AW:0] LIM = (AW+1)'(LIMIT);

    assign data_o = ({1'b0, addr_i} >= LIM) ? FILL : data_i;
endmodule

// File: rtl/irq_step_ctr.sv
// Counts cycles spent inside a sequence; returns to zero when idle.
module irq_step_ctr #(
    parameter int unsigned CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run_i ? cnt_q + CW'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int unsigned PC_W      = 15,
    parameter int unsigned SP_W      = 8,
    parameter int unsigned RAM_TOP   = 'h6F,
    parameter int unsigned ROM_WORDS = 2048,
    parameter int unsigned VECTOR    = 'h00FF,
    parameter int unsigned ENTRY_CYC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_irq_i,
    input  logic            swi_i,
    input  logic            ret_i,
    input  logic            retsk_i,
    input  logic            reti_i,
    input  logic            gie_set_i,
    input  logic            gie_clr_i,
    input  logic            pc_inc_i,
    output logic [PC_W-1:0] rom_addr_o,
    input  logic [7:0]      rom_rdata_i,
    output logic [7:0]      rom_data_o,
    output logic            mem_we_o,
    output logic [SP_W-1:0] mem_addr_o,
    output logic [7:0]      mem_wdata_o,
    input  logic [7:0]      mem_rdata_i,
    output logic [PC_W-1:0] pc_o,
    output logic [SP_W-1:0] sp_o,
    output logic            gie_o,
    output logic            busy_o
);
    localparam int unsigned HI_W = PC_W - 8;
    localparam int unsigned CW   = $clog2(ENTRY_CYC + 1);
    localparam logic [CW-1:0]   LAST_STEP = CW'(ENTRY_CYC - 1);
    localparam logic [PC_W-1:0] VEC_PC    = PC_W'(VECTOR);
    localparam logic [SP_W-1:0] SP_RESET  = SP_W'(RAM_TOP);

    typedef struct packed {
        seq_st_e         st;
        ret_kind_e       kind;
        logic            gie;
        logic [SP_W-1:0] sp;
        logic [PC_W-1:0] pc;
        logic [HI_W-1:0] hi;
    } regs_t;

    regs_t         r_d, r_q;
    logic [CW-1:0] step;
    logic [7:0]    ram_rd;

    irq_step_ctr #(.CW(CW)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (r_q.st != ST_IDLE),
        .cnt_o (step)
    );

    irq_mem_guard #(.AW(SP_W), .LIMIT(RAM_TOP + 1), .FILL(8'hFF)) u_ram_guard (
        .addr_i (mem_addr_o),
        .data_i (mem_rdata_i),
        .data_o (ram_rd)
    );

    irq_mem_guard #(.AW(PC_W), .LIMIT(ROM_WORDS), .FILL(8'h00)) u_rom_guard (
        .addr_i (r_q.pc),
        .data_i (rom_rdata_i),
        .data_o (rom_data_o)
    );

    always_comb begin
        r_d         = r_q;
        mem_we_o    = 1'b0;
        mem_addr_o  = r_q.sp;
        mem_wdata_o = 8'h00;
        unique case (r_q.st)
            ST_IDLE: begin
                if (gie_set_i) r_d.gie = 1'b1;
                if (gie_clr_i) r_d.gie = 1'b0;
                if (swi_i) begin
                    r_d.st = ST_ENTRY;
                end else if (hw_irq_i && r_q.gie) begin
                    // enable is sampled from the register, so a clear in this cycle is too late
                    r_d.st  = ST_ENTRY;
                    r_d.gie = 1'b0;
                end else if (reti_i) begin
                    r_d.st   = ST_RETURN;
                    r_d.kind = RK_IRQ;
                end else if (retsk_i) begin
                    r_d.st   = ST_RETURN;
                    r_d.kind = RK_SKIP;
                end else if (ret_i) begin
                    r_d.st   = ST_RETURN;
                    r_d.kind = RK_PLAIN;
                end else if (pc_inc_i) begin
                    r_d.pc = r_q.pc + PC_W'(1);
                end
            end
            ST_ENTRY: begin
                if (step == CW'(0)) begin
                    mem_we_o    = 1'b1;
                    mem_wdata_o = r_q.pc[7:0];
                end else if (step == CW'(1)) begin
                    mem_we_o    = 1'b1;
                    mem_addr_o  = r_q.sp - SP_W'(1);
                    mem_wdata_o = 8'(r_q.pc[PC_W-1:8]);
                end
                if (step == LAST_STEP) begin
                    r_d.st = ST_IDLE;
                    r_d.pc = VEC_PC;
                    r_d.sp = r_q.sp - SP_W'(2);
                end
            end
            ST_RETURN: begin
                if (step == CW'(0)) begin
                    mem_addr_o = r_q.sp + SP_W'(1);
                    r_d.hi     = ram_rd[HI_W-1:0];
                end else begin
                    mem_addr_o = r_q.sp + SP_W'(2);
                    r_d.pc     = {r_q.hi, ram_rd} + PC_W'(r_q.kind == RK_SKIP);
                    r_d.sp     = r_q.sp + SP_W'(2);
                    if (r_q.kind == RK_IRQ) r_d.gie = 1'b1;
                    r_d.st     = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.kind <= RK_PLAIN;
            r_q.gie  <= 1'b0;
            r_q.sp   <= SP_RESET;
            r_q.pc   <= '0;
            r_q.hi   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rom_addr_o = r_q.pc;
    assign pc_o       = r_q.pc;
    assign sp_o       = r_q.sp;
    assign gie_o      = r_q.gie;
    assign busy_o     = (r_q.st != ST_IDLE);
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
    parameter int unsigned PC_W = 15,
    parameter int unsigned SP_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hw_irq_i,
    input logic            swi_i,
    input logic            ret_i,
    input logic            retsk_i,
    input logic            reti_i,
    input logic            gie_set_i,
    input logic            gie_clr_i,
    input logic            mem_we_o,
    input logic [SP_W-1:0] sp_o,
    input logic [PC_W-1:0] pc_o,
    input logic            gie_o,
    input logic            busy_o
);
    p_we_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    p_hw_clears_gie_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && hw_irq_i && gie_o && !swi_i) |=> (busy_o && !gie_o));

    p_swi_keeps_gie_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && swi_i && !gie_set_i && !gie_clr_i) |=> (busy_o && gie_o == $past(gie_o)));

    p_masked_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !swi_i && !ret_i && !retsk_i && !reti_i && !(hw_irq_i && gie_o))
        |=> (!busy_o && (pc_o == $past(pc_o) || pc_o == $past(pc_o) + PC_W'(1))));

    p_sp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (sp_o == $past(sp_o) + SP_W'(2) || sp_o == $past(sp_o) - SP_W'(2)));

    p_sp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(sp_o) || !busy_o);
endmodule

bind irq_seq irq_seq_chk #(.PC_W(PC_W), .SP_W(SP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_irq_i  (hw_irq_i),
    .swi_i     (swi_i),
    .ret_i     (ret_i),
    .retsk_i   (retsk_i),
    .reti_i    (reti_i),
    .gie_set_i (gie_set_i),
    .gie_clr_i (gie_clr_i),
    .mem_we_o  (mem_we_o),
    .sp_o      (sp_o),
    .pc_o      (pc_o),
    .gie_o     (gie_o),
    .busy_o    (busy_o)
);

// File: tb/irq_seq_bench.sv
module irq_seq_bench;
    localparam int PC_W = 15;
    localparam int SP_W = 8;
    localparam int RAM_TOP = 'h6F;
    localparam int ROM_WORDS = 2048;
    localparam int VECTOR = 'h00FF;
    localparam int ENTRY_CYC = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_irq_i = 0, swi_i = 0, ret_i = 0, retsk_i = 0, reti_i = 0;
    logic gie_set_i = 0, gie_clr_i = 0, pc_inc_i = 0;
    logic [PC_W-1:0] rom_addr_o;
    logic [7:0] rom_rdata_i, rom_data_o;
    logic mem_we_o;
    logic [SP_W-1:0] mem_addr_o;
    logic [7:0] mem_wdata_o, mem_rdata_i;
    logic [PC_W-1:0] pc_o;
    logic [SP_W-1:0] sp_o;
    logic gie_o, busy_o;

    always #5 clk = ~clk;

    logic [7:0] ram [256];
    assign mem_rdata_i = ram[mem_addr_o];
    always @(posedge clk) if (mem_we_o) ram[mem_addr_o] <= mem_wdata_o;
    assign rom_rdata_i = rom_addr_o[7:0] ^ 8'hA5;

    irq_seq u_irq_seq (
        .clk(clk), .rst_n(rst_n), .hw_irq_i(hw_irq_i), .swi_i(swi_i),
        .ret_i(ret_i), .retsk_i(retsk_i), .reti_i(reti_i),
        .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i), .pc_inc_i(pc_inc_i),
        .rom_addr_o(rom_addr_o), .rom_rdata_i(rom_rdata_i), .rom_data_o(rom_data_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .pc_o(pc_o), .sp_o(sp_o), .gie_o(gie_o), .busy_o(busy_o)
    );

    int n_cmp = 0, n_bad = 0, depth = 0;
    bit done = 0;
    logic [PC_W-1:0] exp_pc;
    logic [SP_W-1:0] exp_sp;
    logic exp_gie;
    logic [7:0] exp_ram [256];

    function automatic logic [7:0] f_ram_rd(input logic [SP_W-1:0] a);
        return (int'(a) > RAM_TOP) ? 8'hFF : exp_ram[a];
    endfunction

    function automatic logic [7:0] f_rom(input logic [PC_W-1:0] a);
        return (int'(a) >= ROM_WORDS) ? 8'h00 : (a[7:0] ^ 8'hA5);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk(req, "pc", 32'(pc_o), 32'(exp_pc));
        chk(req, "sp", 32'(sp_o), 32'(exp_sp));
        chk(req, "gie", 32'(gie_o), 32'(exp_gie));
        chk("R9", "rom byte", 32'(rom_data_o), 32'(f_rom(exp_pc)));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_pc = '0; exp_sp = SP_W'(RAM_TOP); exp_gie = 1'b0; depth = 0;
        @(negedge clk);
    endtask

    // one operation: drive strobes for one cycle, wait out the sequence, compare with the model
    task automatic run_op(input string req, input logic hw, input logic sw, input logic rt,
                          input logic rs, input logic ri, input logic gs, input logic gc, input logic inc);
        logic take_sw, take_hw, is_ret;
        logic [SP_W-1:0] sp0;
        logic [PC_W-1:0] pc0;
        logic [7:0] hi, lo;
        int nbusy;
        take_sw = sw;
        take_hw = !sw && hw && exp_gie;
        is_ret  = !take_sw && !take_hw && (rt || rs || ri);
        sp0 = exp_sp; pc0 = exp_pc;
        hw_irq_i = hw; swi_i = sw; ret_i = rt; retsk_i = rs; reti_i = ri;
        gie_set_i = gs; gie_clr_i = gc; pc_inc_i = inc;
        @(negedge clk);
        hw_irq_i = 0; swi_i = 0; ret_i = 0; retsk_i = 0; reti_i = 0;
        gie_set_i = 0; gie_clr_i = 0; pc_inc_i = 0;
        nbusy = (take_sw || take_hw) ? ENTRY_CYC : (is_ret ? 2 : 0);
        for (int k = 0; k < nbusy; k++) begin
            chk(req, "busy during sequence", 32'(busy_o), 32'd1);
            @(negedge clk);
        end
        chk(req, "busy after", 32'(busy_o), 32'd0);
        if (gs) exp_gie = 1'b1;
        if (gc) exp_gie = 1'b0;
        if (take_sw || take_hw) begin
            if (take_hw) exp_gie = 1'b0;
            exp_ram[sp0] = pc0[7:0];
            exp_ram[sp0 - 1] = 8'(pc0[PC_W-1:8]);
            exp_sp = sp0 - 2;
            exp_pc = PC_W'(VECTOR);
            depth++;
            chk("R3", "low byte at SP", 32'(ram[sp0]), 32'(pc0[7:0]));
            chk("R3", "high byte at SP-1", 32'(ram[sp0 - 1]), 32'(8'(pc0[PC_W-1:8])));
        end else if (is_ret) begin
            hi = f_ram_rd(sp0 + 1);
            lo = f_ram_rd(sp0 + 2);
            exp_pc = {hi[PC_W-9:0], lo} + PC_W'(rs);
            exp_sp = sp0 + 2;
            if (ri) exp_gie = 1'b1;
            if (depth > 0) depth--;
        end else if (inc) begin
            exp_pc = pc0 + 1;
        end
        check_state(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) exp_ram[i] = 8'h00;
        do_reset();
        // R1 reset values
        chk("R1", "busy", 32'(busy_o), 32'd0);
        check_state("R1");

        run_op("R12", 0, 0, 0, 0, 0, 0, 0, 1);           // PC advance while idle
        run_op("R4", 0, 1, 0, 0, 0, 0, 0, 0);            // software entry, enable stays 0
        run_op("R6", 0, 0, 0, 0, 1, 0, 0, 0);            // return-from-interrupt sets enable
        run_op("R10", 1, 0, 0, 0, 0, 0, 1, 0);           // clear in accepting cycle, still taken
        run_op("R11", 0, 0, 0, 0, 0, 1, 0, 0);           // set enable inside handler
        run_op("R11", 1, 0, 0, 0, 0, 0, 0, 0);           // nested hardware entry
        run_op("R6", 0, 0, 1, 0, 0, 0, 0, 0);            // plain return keeps enable 0
        run_op("R6", 0, 0, 0, 0, 1, 0, 0, 0);
        run_op("R5", 0, 0, 0, 0, 0, 0, 1, 0);
        run_op("R5", 1, 0, 0, 0, 0, 0, 0, 0);            // masked request ignored
        run_op("R2", 0, 1, 0, 0, 0, 0, 0, 0);
        run_op("R7", 0, 0, 0, 1, 0, 0, 0, 0);            // skip past saved address
        run_op("R11", 0, 0, 0, 0, 0, 1, 0, 0);
        run_op("R13", 1, 1, 0, 0, 0, 0, 0, 0);           // software wins, enable stays 1
        run_op("R13", 0, 0, 0, 0, 1, 0, 0, 0);

        // R12: strobes during an entry have no effect
        swi_i = 1; @(negedge clk);
        swi_i = 0; ret_i = 1; pc_inc_i = 1; gie_clr_i = 1; @(negedge clk);
        ret_i = 0; pc_inc_i = 0; gie_clr_i = 0;
        repeat (ENTRY_CYC - 1) @(negedge clk);
        exp_ram[exp_sp] = exp_pc[7:0];
        exp_ram[exp_sp - 1] = 8'(exp_pc[PC_W-1:8]);
        exp_sp = exp_sp - 2; exp_pc = PC_W'(VECTOR); depth++;
        chk("R12", "busy after entry", 32'(busy_o), 32'd0);
        check_state("R12");
        run_op("R12", 0, 0, 0, 1, 0, 0, 0, 0);

        // random traffic
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom % 8);
            if (depth >= 10 && op <= 2) op = 5;
            if (depth == 0 && op >= 3 && op <= 5) op = 0;
            case (op)
                0: run_op("R12", 0, 0, 0, 0, 0, 0, 0, 1);
                1: run_op("R2", 1, 0, 0, 0, 0, 0, 0, 0);
                2: run_op("R2", 0, 1, 0, 0, 0, 0, 0, 0);
                3: run_op("R6", 0, 0, 1, 0, 0, 0, 0, 0);
                4: run_op("R7", 0, 0, 0, 1, 0, 0, 0, 0);
                5: run_op("R6", 0, 0, 0, 0, 1, 0, 0, 0);
                6: run_op("R11", 0, 0, 0, 0, 0, 1, 0, 0);
                default: run_op("R11", 0, 0, 0, 0, 0, 0, 1, 0);
            endcase
        end

        // R8: unbalanced return on an empty stack traps to all ones, program byte 0x00
        do_reset();
        run_op("R8", 0, 0, 1, 0, 0, 0, 0, 0);
        chk("R8", "pc all ones", 32'(pc_o), 32'(15'h7FFF));
        chk("R9", "trap byte", 32'(rom_data_o), 32'h00);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule